// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a single-ported synchronous SRAM. Each word is built from four byte lanes of 8 or 9 bits. The bidirectional data bus is split into a write-data input, a read-data output and an output-drive flag. Every rising clock edge where the active-low clock enable is asserted is one cycle. In that cycle the block decodes three chip selects, a load/advance strobe, a read/write select and four active-low lane-write strobes. It then either opens a burst at the external address, continues the current burst from a 2-bit internal counter, or deselects.

Read data is flow-through. The word at the current cycle address appears on the output straight after the clock edge. There is no output register and no dead cycle between a write and a read. The cycle type (read, write or deselect) is fixed by the cycle that opens a burst. Continue cycles repeat that type and ignore the select and direction pins.

The output-enable pin acts combinationally and can suppress the output drive. This gives dummy reads, which still count as burst cycles. Writes with all lane strobes high are aborted, but they still advance the burst. Holding the clock enable high freezes the whole block.

Top module: `fts_sram`

## Requirements
- R1: After reset, `dout_en` is low.
- R2: A cycle with `adv_ld` low and any chip select inactive is a deselect: `sel0_n` high, `sel1` low or `sel2_n` high. After it, `dout_en` is low, and it stays low through the continue cycles that follow.
- R3: A load cycle opens a read burst when all three selects are active, `adv_ld` is low and `rd_wr_n` is high. After the edge, `dout` carries the stored word at `addr` and `dout_en` equals the inverse of the current `oe_n`.
- R4: On a write cycle, lane l (bits l*LANE_W up to l*LANE_W+LANE_W-1) takes `din` when `bw_n[l]` is low, and the other lanes keep their contents. `dout_en` stays low throughout a write burst, whatever `oe_n` is.
- R5: A cycle with `adv_ld` high repeats the type of the last load cycle and ignores the chip selects and `rd_wr_n`. For read and write bursts, the low two address bits step by one modulo 4 and the upper address bits do not change. The fifth burst cycle therefore returns to the start word.
- R6: A read cycle with `oe_n` high drives nothing (`dout_en` low). The burst counter still advances on such continue cycles.
- R7: A write cycle with all four `bw_n` bits high writes no lane, leaves `dout_en` low and still advances the burst counter.
- R8: While `clk_en_n` is high, no lane is written and the address, counter and cycle type hold their values. If `oe_n` is unchanged, `dout` and `dout_en` also keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low cycle enable; high inhibits the cycle |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | Low: load address and open a burst; high: continue |
| rd_wr_n | input | 1 | High: read burst, low: write burst (sampled on load) |
| bw_n | input | 4 | Active-low per-lane write strobes |
| oe_n | input | 1 | Active-low output enable, combinational |
| addr | input | ADDR_W | External word address |
| din | input | 4*LANE_W | Write data |
| dout | output | 4*LANE_W | Flow-through read data |
| dout_en | output | 1 | High when the read data is driven |

## Verification
Some properties are checked on every cycle:
- Deselect, write and read load cycles each set the output drive in the cycle that follows.
- Every continue cycle of a live burst steps the low address bits modulo 4 and leaves the upper bits unchanged.
- An inhibited cycle freezes address, type, data and drive, and enables no lane write.

Other behaviour only shows through the scenarios, which compare every returned word against a reference array:
- the merging of partial lane writes;
- that aborted writes leave the stored data intact;
- that dummy reads still move the counter;
- that select and direction pins are ignored on continue cycles.

// File: rtl/fts_pkg.sv
package fts_pkg;
   localparam int unsigned LANES   = 4;
   localparam int unsigned BURST_W = 2;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } cyc_e;
endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
   import fts_pkg::*;
#(
   parameter int unsigned N_LANES = LANES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_en_n,
   input  logic               sel0_n,
   input  logic               sel1,
   input  logic               sel2_n,
   input  logic               adv_ld,
   input  logic               rd_wr_n,
   input  logic [N_LANES-1:0] bw_n,
   output logic               load,
   output logic               step,
   output cyc_e               kind_q,
   output logic [N_LANES-1:0] lane_we
);
   logic selected;
   cyc_e kind_d;

   assign selected = !sel0_n && sel1 && !sel2_n;

   // Load cycles choose the type; continue cycles reuse it.
   always_comb begin
      kind_d = kind_q;
      if (!adv_ld) begin
         if (selected) kind_d = rd_wr_n ? CYC_READ : CYC_WRITE;
         else          kind_d = CYC_IDLE;
      end
   end

   assign load    = !clk_en_n && !adv_ld && selected;
   assign step    = !clk_en_n && adv_ld && (kind_q != CYC_IDLE);
   assign lane_we = (!clk_en_n && kind_d == CYC_WRITE) ? ~bw_n : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         kind_q <= CYC_IDLE;
      else if (!clk_en_n) kind_q <= kind_d;
   end
endmodule

// File: rtl/fts_burst.sv
module fts_burst #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] cyc_addr,
   output logic [ADDR_W-1:0] cur_addr
);
   localparam int unsigned HI_W = ADDR_W - CNT_W;

   generate
      if (ADDR_W <= CNT_W) begin : g_bad_width
         $error("fts_burst: ADDR_W must exceed the counter width");
      end
   endgenerate

   logic [ADDR_W-1:0] base_q, base_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;

   always_comb begin
      base_d = base_q;
      cnt_d  = cnt_q;
      if (load) begin
         base_d = ext_addr;
         cnt_d  = '0;
      end else if (step) begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   // Counter adds to the low bits only; no carry into the upper bits.
   assign cyc_addr = {base_d[ADDR_W-1 -: HI_W], base_d[CNT_W-1:0] + cnt_d};
   assign cur_addr = {base_q[ADDR_W-1 -: HI_W], base_q[CNT_W-1:0] + cnt_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else begin
         base_q <= base_d;
         cnt_q  <= cnt_d;
      end
   end
endmodule

// File: rtl/fts_lane_ram.sv
module fts_lane_ram #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANE_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [LANE_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/fts_sram.sv
module fts_sram
   import fts_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clk_en_n,
   input  logic                      sel0_n,
   input  logic                      sel1,
   input  logic                      sel2_n,
   input  logic                      adv_ld,
   input  logic                      rd_wr_n,
   input  logic [LANES-1:0]          bw_n,
   input  logic                      oe_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES*LANE_W-1:0]   din,
   output logic [LANES*LANE_W-1:0]   dout,
   output logic                      dout_en
);
   localparam int unsigned WORD_W = LANES * LANE_W;

   generate
      if (LANE_W != 8 && LANE_W != 9) begin : g_bad_lane
         $error("fts_sram: LANE_W must be 8 or 9");
      end
      if (ADDR_W > 16) begin : g_bad_depth
         $error("fts_sram: ADDR_W above 16 is not supported");
      end
   endgenerate

   logic              load, step;
   cyc_e              kind_q;
   logic [LANES-1:0]  lane_we;
   logic [ADDR_W-1:0] cyc_addr, cur_addr;

   fts_ctrl #(.N_LANES(LANES)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_en_n (clk_en_n),
      .sel0_n   (sel0_n),
      .sel1     (sel1),
      .sel2_n   (sel2_n),
      .adv_ld   (adv_ld),
      .rd_wr_n  (rd_wr_n),
      .bw_n     (bw_n),
      .load     (load),
      .step     (step),
      .kind_q   (kind_q),
      .lane_we  (lane_we)
   );

   fts_burst #(.ADDR_W(ADDR_W), .CNT_W(BURST_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step),
      .ext_addr (addr),
      .cyc_addr (cyc_addr),
      .cur_addr (cur_addr)
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         fts_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
            .clk   (clk),
            .we    (lane_we[l]),
            .waddr (cyc_addr),
            .wdata (din[l*LANE_W +: LANE_W]),
            .raddr (cur_addr),
            .rdata (dout[l*LANE_W +: LANE_W])
         );
      end
   endgenerate

   // Output drive: only read bursts, gated by the asynchronous enable.
   assign dout_en = (kind_q == CYC_READ) && !oe_n;
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned WORD_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en_n,
   input logic              sel0_n,
   input logic              sel1,
   input logic              sel2_n,
   input logic              adv_ld,
   input logic              rd_wr_n,
   input logic              oe_n,
   input logic [WORD_W-1:0] dout,
   input logic              dout_en,
   input logic [ADDR_W-1:0] cur_addr,
   input logic [1:0]        kind,
   input logic [3:0]        lane_we
);
   logic sel_ok;
   assign sel_ok = !sel0_n && sel1 && !sel2_n;

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !dout_en);

   p_deselect_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv_ld && !sel_ok) |=> !dout_en);

   p_read_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv_ld && sel_ok && rd_wr_n) |=> (dout_en == !oe_n));

   p_write_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv_ld && sel_ok && !rd_wr_n) |=> !dout_en);

   p_burst_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && adv_ld && kind != 2'd0) |=>
         (cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)) &&
         (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

   p_inhibit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(cur_addr) && $stable(kind) &&
         (!$stable(oe_n) || ($stable(dout_en) && $stable(dout))));

   p_inhibit_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |-> (lane_we == 4'b0000));
endmodule

bind fts_sram fts_sram_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clk_en_n (clk_en_n),
   .sel0_n   (sel0_n),
   .sel1     (sel1),
   .sel2_n   (sel2_n),
   .adv_ld   (adv_ld),
   .rd_wr_n  (rd_wr_n),
   .oe_n     (oe_n),
   .dout     (dout),
   .dout_en  (dout_en),
   .cur_addr (cur_addr),
   .kind     (kind_q),
   .lane_we  (lane_we)
);

// File: tb/sim_fts_sram.sv
module sim_fts_sram;
   localparam int AW = 8;
   localparam int LW = 9;
   localparam int W  = 4 * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_n = 1'b1;
   logic          sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
   logic          adv_ld = 1'b0, rd_wr_n = 1'b1, oe_n = 1'b0;
   logic [3:0]    bw_n = 4'hF;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  din = '0;
   logic [W-1:0]  dout;
   logic          dout_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fts_sram #(.ADDR_W(AW), .LANE_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
      .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
      .adv_ld(adv_ld), .rd_wr_n(rd_wr_n), .bw_n(bw_n), .oe_n(oe_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
   );

   // Reference model: 0 idle, 1 read, 2 write
   logic [W-1:0]  mdl [DEPTH];
   int            m_kind = 0;
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = '0;

   typedef struct {
      bit           act;
      logic [W-1:0] data;
      string        tag;
   } exp_t;
   exp_t sb[$];

   function automatic logic [AW-1:0] m_addr();
      return {m_base[AW-1:2], 2'(m_base[1:0] + m_cnt)};
   endfunction

   task automatic note(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: apply one cycle, update the model, push the expectation.
   task automatic cyc(input bit ce_n, input bit s0n, input bit s1, input bit s2n,
                      input bit adv, input bit rw, input logic [3:0] bw, input bit oe,
                      input logic [AW-1:0] a, input logic [W-1:0] d, input string tag);
      exp_t e;
      clk_en_n = ce_n; sel0_n = s0n; sel1 = s1; sel2_n = s2n;
      adv_ld = adv; rd_wr_n = rw; bw_n = bw; oe_n = oe; addr = a; din = d;
      @(posedge clk);
      if (!ce_n) begin
         if (!adv) begin
            if (!s0n && s1 && !s2n) begin
               m_base = a; m_cnt = 2'd0; m_kind = rw ? 1 : 2;
            end else m_kind = 0;
         end else if (m_kind != 0) m_cnt = m_cnt + 2'd1;
         if (m_kind == 2)
            for (int l = 0; l < 4; l++)
               if (!bw[l]) mdl[m_addr()][l*LW +: LW] = d[l*LW +: LW];
      end
      e.act = (m_kind == 1);
      e.data = mdl[m_addr()];
      e.tag = tag;
      sb.push_back(e);
      #4;
   endtask

   // Monitor: compare at the falling edge against the current oe_n.
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         bit exp_en;
         e = sb.pop_front();
         exp_en = e.act && !oe_n;
         note(dout_en == exp_en, {e.tag, " drive"}, W'(dout_en), W'(exp_en));
         if (exp_en) note(dout == e.data, {e.tag, " data"}, dout, e.data);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   function automatic logic [W-1:0] rnd_word();
      return {4'($urandom), $urandom};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #4 rst_n = 1'b1;
      @(negedge clk);
      note(dout_en == 1'b0, "R1 reset drive", W'(dout_en), '0);
      @(posedge clk); #4;

      // R4: fill memory with full-word write bursts; continues use bogus selects (R5)
      for (int b = 0; b < DEPTH / 4; b++) begin
         cyc(0, 0, 1, 0, 0, 0, 4'h0, 0, AW'(b * 4), rnd_word(), "R4 fill");
         for (int k = 0; k < 3; k++)
            cyc(0, 1, 0, 1, 1, 1, 4'h0, 0, '0, rnd_word(), "R4 fill cont");
      end

      // R3/R5: read burst starting at low bits 2, five cycles to show wrap
      cyc(0, 0, 1, 0, 0, 1, 4'hF, 0, 8'h0E, '0, "R3 read load");
      for (int k = 0; k < 4; k++)
         cyc(0, k[0], !k[0], 1, 1, 0, 4'h0, 0, 8'hFF, rnd_word(), "R5 read wrap");

      // R2: each select inactive, then continue-deselect
      cyc(0, 1, 1, 0, 0, 1, 4'hF, 0, 8'h10, '0, "R2 sel0 off");
      cyc(0, 0, 0, 0, 0, 1, 4'hF, 0, 8'h10, '0, "R2 sel1 off");
      cyc(0, 0, 1, 1, 0, 1, 4'hF, 0, 8'h10, '0, "R2 sel2 off");
      cyc(0, 0, 1, 0, 1, 1, 4'h0, 0, 8'h10, rnd_word(), "R2 continue deselect");
      cyc(0, 0, 1, 0, 1, 0, 4'h0, 0, 8'h10, rnd_word(), "R2 continue deselect");
      cyc(0, 0, 1, 0, 0, 1, 4'hF, 0, 8'h10, '0, "R2 reselect read");

      // R6: dummy read then continue with output on
      cyc(0, 0, 1, 0, 0, 1, 4'hF, 1, 8'h21, '0, "R6 dummy load");
      cyc(0, 0, 1, 0, 1, 1, 4'hF, 1, '0, '0, "R6 dummy cont");
      cyc(0, 0, 1, 0, 1, 1, 4'hF, 0, '0, '0, "R6 advanced read");

      // R4/R7: partial write, abort, partial write, read back
      cyc(0, 0, 1, 0, 0, 0, 4'b1010, 0, 8'h40, rnd_word(), "R4 partial");
      cyc(0, 0, 1, 0, 1, 0, 4'b1111, 0, '0, rnd_word(), "R7 abort");
      cyc(0, 0, 1, 0, 1, 0, 4'b0111, 0, '0, rnd_word(), "R4 partial cont");
      cyc(0, 0, 1, 0, 1, 0, 4'b1111, 0, '0, rnd_word(), "R7 abort");
      cyc(0, 0, 1, 0, 0, 1, 4'hF, 0, 8'h40, '0, "R7 readback");
      for (int k = 0; k < 3; k++)
         cyc(0, 0, 1, 0, 1, 1, 4'hF, 0, '0, '0, "R7 readback cont");

      // R8: inhibit during read, then during write
      cyc(0, 0, 1, 0, 0, 1, 4'hF, 0, 8'h33, '0, "R8 read load");
      cyc(1, 0, 1, 0, 0, 0, 4'h0, 0, 8'h80, rnd_word(), "R8 inhibit read");
      cyc(1, 0, 1, 0, 1, 0, 4'h0, 0, 8'h81, rnd_word(), "R8 inhibit read");
      cyc(0, 0, 1, 0, 1, 1, 4'hF, 0, '0, '0, "R8 resume read");
      cyc(0, 0, 1, 0, 0, 0, 4'hF, 0, 8'h50, '0, "R8 write load");
      cyc(1, 0, 1, 0, 1, 0, 4'h0, 0, 8'h50, rnd_word(), "R8 inhibit write");
      cyc(0, 0, 1, 0, 0, 1, 4'hF, 0, 8'h50, '0, "R8 no write check");
      cyc(0, 0, 1, 0, 1, 1, 4'hF, 0, '0, '0, "R8 no write check");

      // Random mix of every cycle kind
      for (int n = 0; n < 1500; n++) begin
         bit ce, s0, s1v, s2, ad, rw, oe;
         logic [3:0] bw;
         ce  = ($urandom_range(7) == 0);
         s0  = ($urandom_range(9) == 0);
         s1v = ($urandom_range(9) != 0);
         s2  = ($urandom_range(9) == 0);
         ad  = ($urandom_range(2) != 0);
         rw  = $urandom_range(1);
         oe  = ($urandom_range(4) == 0);
         bw  = ($urandom_range(3) == 0) ? 4'hF : 4'($urandom);
         cyc(ce, s0, s1v, s2, ad, rw, bw, oe, AW'($urandom), rnd_word(), "R5 R6 R7 R8 random");
      end

      clk_en_n = 1'b1;
      repeat (3) @(posedge clk);
      finish_run();
   end
endmodule